// File: doc/BRIEF.md
# Edge Interval Capture Engine

This block measures the spacing between successive transitions of one asynchronous digital input. The input is first brought into the clock domain and edge-detected. A free-running interval timer is then used, advancing once for every 64 system clocks. The first rising transition arms the block and restarts the timer. From then on, every transition of either polarity stores the current timer reading as a 16-bit entry in an internal buffer and restarts the timer. In this way each entry holds the length of one level period of the input.

Capture stops for one of two reasons: the buffer fills up, or the timer wraps before another transition arrives. The block tells a separate controller which of the two happened with a one-cycle terminal pulse, together with a one-cycle done pulse. After that it holds a sticky finished level. The controller reads the buffer one byte at a time through a combinational read port and uses the captured-entry count to know how many entries are valid. Serial transport and command decoding are outside this block.

Top module: `edge_interval_capture`

## Requirements
- R1: After reset, every one of the 110 buffer bytes reads 0x23, `entry_count` is 0, and both `running` and `finished` are low.
- R2: While idle, a falling transition of the input is ignored. The first rising transition raises `running` but stores no entry, so `entry_count` stays 0.
- R3: While running, each transition of either polarity writes one entry at index `entry_count`, raises `entry_count` by one and restarts the timer at zero.
- R4: The timer advances once per 64 clocks. When two recognised transitions are D clocks apart, the stored entry equals floor((D-1)/64).
- R5: Entry i occupies byte address 2i (bits 15:8) and byte address 2i+1 (bits 7:0). Any address at or beyond 110 reads 0x00.
- R6: The 55th stored entry ends capture. `term_capacity` pulses for one cycle, `running` falls and `finished` rises. Later transitions change neither `entry_count` nor the buffer.
- R7: If the timer wraps while running and no transition arrives in that cycle, `term_overflow` pulses for one cycle and capture ends with no entry stored.
- R8: If a transition arrives in the same cycle that the timer would wrap, the transition wins. The all-ones timer value is stored, no overflow is signalled, and capture continues.
- R9: `done` is a single-cycle pulse that coincides with exactly one terminal pulse. `finished` then stays high until reset.
- R10: The input passes through two synchronising flops. Transitions are not recognised during the first three cycles after reset, so a level that is already present at reset is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous input whose transitions are timed |
| rd_addr | input | 7 | Byte address into the capture buffer |
| rd_data | output | 8 | Buffer byte at `rd_addr` (combinational) |
| entry_count | output | 6 | Number of entries stored so far |
| running | output | 1 | Armed and capturing |
| finished | output | 1 | Capture has ended (sticky until reset) |
| done | output | 1 | One-cycle pulse when capture ends |
| term_capacity | output | 1 | One-cycle pulse: capture ended because the buffer is full |
| term_overflow | output | 1 | One-cycle pulse: capture ended because the timer wrapped |

## Verification
A transition capture and a timer wrap can fall in the same cycle. The design resolves this in favour of the capture. The bench provokes the collision with a reduced timer width of 9 bits: it spaces two input transitions exactly 512×64 clocks apart, so the recognised edge lands on the cycle in which the timer would wrap. Correct handling is judged at the ports. The entry must read 0x01FF, `entry_count` must step, `running` must stay high, and no overflow or done pulse may appear. Afterwards the input is left quiet for a full period, so that the genuine wrap is seen to end capture without storing anything.

// File: rtl/ec_pkg.sv
// Package: shared types for the edge interval capture engine.
// Assumes nothing beyond IEEE 1800-2017; imported by the top module.
package ec_pkg;

    // Width of one stored interval entry (two bytes).
    localparam int ENTRY_W = 16;

    // Capture sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cap_state_t;

endpackage

// File: rtl/ec_edge_detect.sv
// Module: two-flop synchroniser followed by an edge detector.
// Emits a rising-edge strobe and an any-edge strobe, each one cycle wide.
// Assumes sig_in is asynchronous. Strobes are held off until the pipeline
// holds only post-reset samples, so a level present at reset is not an edge.
module ec_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise,
    output logic any_edge
);

    logic       sync1, sync2, prev;
    logic [1:0] fill;
    logic       valid;

    // Synchronise the input, keep the previous sample, count settle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
            fill  <= 2'd0;
        end else begin
            sync1 <= sig_in;
            sync2 <= sync1;
            prev  <= sync2;
            if (fill != 2'd3) fill <= fill + 2'd1;
        end
    end

    // Compare the current and previous synchronised samples once settled.
    always_comb begin
        valid    = (fill == 2'd3);
        rise     = valid & sync2 & ~prev;
        any_edge = valid & (sync2 ^ prev);
    end

endmodule

// File: rtl/ec_interval_timer.sv
// Module: prescaled interval timer.
// The count advances once every PRESCALE enabled clocks. clear restarts
// both the prescaler and the count, and takes priority over counting.
// wrap flags the cycle in which an all-ones count would roll over;
// it is suppressed when clear is asserted. Assumes TW <= 16.
module ec_interval_timer #(
    parameter int PRESCALE = 64,
    parameter int TW       = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        clear,
    output logic [15:0] value,
    output logic        wrap
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PRE_W-1:0] pre;
    logic [TW-1:0]    cnt;
    logic             tick;

    // Prescaler terminal count marks a timer step.
    always_comb begin
        tick  = (pre == PRE_W'(PRESCALE - 1));
        wrap  = enable & ~clear & tick & (&cnt);
        value = 16'(cnt);
    end

    // Advance or restart the prescaler and the interval count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            cnt <= '0;
        end else if (clear) begin
            pre <= '0;
            cnt <= '0;
        end else if (enable) begin
            pre <= tick ? '0 : pre + PRE_W'(1);
            if (tick) cnt <= cnt + TW'(1);
        end
    end

endmodule

// File: rtl/ec_sample_store.sv
// Module: interval buffer of DEPTH 16-bit entries with a byte read port.
// Reset fills every byte with FILL. One entry is written per wr_en cycle.
// Byte 2i returns bits 15:8 of entry i and byte 2i+1 returns bits 7:0.
// Addresses past the end read zero. Assumes wr_idx < DEPTH when wr_en.
module ec_sample_store #(
    parameter int         DEPTH  = 55,
    parameter logic [7:0] FILL   = 8'h23,
    parameter int         IDX_W  = $clog2(DEPTH),
    parameter int         ADDR_W = $clog2(2 * DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [15:0]      mem [DEPTH];
    logic [IDX_W-1:0] rd_idx;

    // Preset the whole buffer on reset, otherwise store one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= {FILL, FILL};
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Select the addressed byte, high byte at the even address.
    always_comb begin
        rd_idx  = rd_addr[ADDR_W-1:1];
        rd_data = 8'h00;
        if (32'(rd_addr) < 2 * DEPTH)
            rd_data = rd_addr[0] ? mem[rd_idx][7:0] : mem[rd_idx][15:8];
    end

endmodule

// File: rtl/edge_interval_capture.sv
// Module: edge interval capture engine (top).
// Arms on the first rising input edge, then stores the timer reading at
// every edge of either polarity and restarts the timer. Ends on a full
// buffer or on a timer wrap and pulses done plus one terminal flag.
// Assumes a single clock domain; sig_in may be asynchronous.
module edge_interval_capture
    import ec_pkg::*;
#(
    parameter int         DEPTH    = 55,
    parameter int         PRESCALE = 64,
    parameter int         TW       = 16,
    parameter logic [7:0] FILL     = 8'h23,
    localparam int        CNT_W    = $clog2(DEPTH + 1),
    localparam int        ADDR_W   = $clog2(2 * DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [CNT_W-1:0]  entry_count,
    output logic              running,
    output logic              finished,
    output logic              done,
    output logic              term_capacity,
    output logic              term_overflow
);

    localparam int IDX_W = $clog2(DEPTH);

    cap_state_t  state;
    logic        rise, any_edge;
    logic        tmr_en, tmr_clr, tmr_wrap, store;
    logic [15:0] tmr_val;

    ec_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sig_in),
        .rise     (rise),
        .any_edge (any_edge)
    );

    ec_interval_timer #(.PRESCALE(PRESCALE), .TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (tmr_en),
        .clear  (tmr_clr),
        .value  (tmr_val),
        .wrap   (tmr_wrap)
    );

    ec_sample_store #(.DEPTH(DEPTH), .FILL(FILL)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store),
        .wr_idx  (entry_count[IDX_W-1:0]),
        .wr_data (tmr_val),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Derive timer control and buffer write strobe from the state.
    always_comb begin
        store    = (state == ST_RUN) && any_edge;
        tmr_en   = (state == ST_RUN);
        tmr_clr  = ((state == ST_IDLE) && rise) || store;
        running  = (state == ST_RUN);
        finished = (state == ST_DONE);
    end

    // Sequence arming, capture and termination; edge beats timer wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            entry_count   <= '0;
            done          <= 1'b0;
            term_capacity <= 1'b0;
            term_overflow <= 1'b0;
        end else begin
            done          <= 1'b0;
            term_capacity <= 1'b0;
            term_overflow <= 1'b0;
            case (state)
                ST_IDLE: if (rise) state <= ST_RUN;
                ST_RUN: begin
                    if (any_edge) begin
                        entry_count <= entry_count + CNT_W'(1);
                        if (entry_count == CNT_W'(DEPTH - 1)) begin
                            state         <= ST_DONE;
                            done          <= 1'b1;
                            term_capacity <= 1'b1;
                        end
                    end else if (tmr_wrap) begin
                        state         <= ST_DONE;
                        done          <= 1'b1;
                        term_overflow <= 1'b1;
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

endmodule

// File: rtl/ec_checker.sv
// Module: port-level property checker for the capture engine, bound below.
// Assumes the top module's port names and the DEPTH parameter.
module ec_checker #(
    parameter int DEPTH = 55,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] entry_count,
    input logic             running,
    input logic             finished,
    input logic             done,
    input logic             term_capacity,
    input logic             term_overflow
);

    // R3: the count never exceeds the buffer depth and moves by at most one.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(entry_count) <= DEPTH);
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (entry_count == $past(entry_count)) ||
                    (entry_count == $past(entry_count) + CNT_W'(1)));

    // R2: with capture not yet armed nothing has been stored.
    a_r2_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !finished) |-> (entry_count == '0));

    // R6: a capacity end is reported only with a full buffer; later edges are ignored.
    a_r6_full_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
        term_capacity |-> (32'(entry_count) == DEPTH));
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> $stable(entry_count) && finished);

    // R9: done lasts one cycle and pairs with exactly one terminal flag.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({term_capacity, term_overflow}) && finished);
    a_r9_term_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        (term_capacity || term_overflow) |-> done);

    // R7: an overflow end leaves the block finished and not running.
    a_r7_ovf_stops: assert property (@(posedge clk) disable iff (!rst_n)
        term_overflow |-> !running);

endmodule

bind edge_interval_capture ec_checker #(.DEPTH(DEPTH)) u_ec_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .entry_count   (entry_count),
    .running       (running),
    .finished      (finished),
    .done          (done),
    .term_capacity (term_capacity),
    .term_overflow (term_overflow)
);

// File: tb/edge_interval_capture_bench.sv
// Directed bench for the edge interval capture engine. The timer width is
// reduced to 9 bits so that a wrap (512*64 clocks) fits in the run time.
module edge_interval_capture_bench;

    localparam int DEPTH = 55;
    localparam int TW    = 9;
    localparam int WRAP  = 512 * 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_in = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [5:0] entry_count;
    logic       running, finished, done, term_capacity, term_overflow;

    int checks = 0;
    int fails = 0;
    int n_done = 0, n_cap = 0, n_ovf = 0;

    always #4 clk = ~clk;

    edge_interval_capture #(.DEPTH(DEPTH), .PRESCALE(64), .TW(TW)) u_edge_interval_capture (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .rd_addr(rd_addr),
        .rd_data(rd_data), .entry_count(entry_count), .running(running),
        .finished(finished), .done(done), .term_capacity(term_capacity),
        .term_overflow(term_overflow)
    );

    // Count output pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) n_done++;
            if (term_capacity) n_cap++;
            if (term_overflow) n_ovf++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        sig_in = lvl;
        rst_n  = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic read_byte(input int a, output int v);
        rd_addr = 7'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic check_entry(input string req, input int idx, input int exp);
        int hi, lo;
        read_byte(2 * idx, hi);
        read_byte(2 * idx + 1, lo);
        check(req, hi, (exp >> 8) & 8'hff);
        check(req, lo, exp & 8'hff);
    endtask

    // Toggle the input, then hold it for d clocks.
    task automatic toggle_hold(input int d);
        sig_in = ~sig_in;
        wait_cyc(d);
    endtask

    // R1: reset state of buffer and flags.
    task automatic t_reset_state();
        int v, bad;
        do_reset(1'b0);
        bad = 0;
        for (int a = 0; a < 2 * DEPTH; a++) begin
            read_byte(a, v);
            if (v != 8'h23) bad++;
        end
        check("R1 fill bytes wrong", bad, 0);
        check("R1 count", int'(entry_count), 0);
        check("R1 running", int'(running), 0);
        check("R1 finished", int'(finished), 0);
        read_byte(2 * DEPTH, v);
        check("R5 beyond end reads zero", v, 0);
    endtask

    // R2, R10: level present at reset and a falling edge do not arm; rise arms.
    task automatic t_idle_arm();
        do_reset(1'b1);
        check("R10 level at reset not an edge", int'(running), 0);
        toggle_hold(20);
        check("R2 fall ignored running", int'(running), 0);
        check("R2 fall ignored count", int'(entry_count), 0);
        toggle_hold(20);
        check("R2 rise arms", int'(running), 1);
        check("R2 arm stores nothing", int'(entry_count), 0);
        check_entry("R2 entry0 untouched", 0, 16'h2323);
    endtask

    // R3, R4, R5, R8, R7, R9: intervals, collision, then genuine wrap.
    task automatic t_intervals_and_wrap();
        int d0, c0, o0;
        do_reset(1'b0);
        toggle_hold(74);          // rise arms
        toggle_hold(10);          // capture 1 (floor(73/64))
        toggle_hold(200);         // capture 0
        toggle_hold(19210);       // capture 3
        toggle_hold(WRAP);        // capture 300
        d0 = n_done; c0 = n_cap; o0 = n_ovf;
        toggle_hold(20);          // capture at wrap cycle: 511
        check("R3 count after five edges", int'(entry_count), 5);
        check_entry("R4 interval 74", 0, 1);
        check_entry("R4 interval 10", 1, 0);
        check_entry("R4 interval 200", 2, 3);
        check_entry("R5 high byte interval 19210", 3, 300);
        check_entry("R8 collision stores max", 4, 511);
        check("R8 still running", int'(running), 1);
        check("R8 no overflow pulse", n_ovf - o0, 0);
        check("R8 no done pulse", n_done - d0, 0);
        check_entry("R3 next entry untouched", 5, 16'h2323);
        wait_cyc(WRAP + 50);
        check("R7 overflow pulse once", n_ovf - o0, 1);
        check("R7 no capacity pulse", n_cap - c0, 0);
        check("R9 done once", n_done - d0, 1);
        check("R7 finished", int'(finished), 1);
        check("R7 not running", int'(running), 0);
        check("R7 no store on wrap", int'(entry_count), 5);
        check_entry("R7 entry5 untouched", 5, 16'h2323);
        toggle_hold(30);
        check("R9 finished sticky", int'(finished), 1);
        check("R7 edge after end ignored", int'(entry_count), 5);
    endtask

    // R6, R9: fill the buffer, then show that further edges are ignored.
    task automatic t_capacity();
        int d0, c0, o0;
        do_reset(1'b0);
        d0 = n_done; c0 = n_cap; o0 = n_ovf;
        toggle_hold(70);          // arm
        for (int i = 0; i < DEPTH; i++) toggle_hold(70);
        check("R6 count full", int'(entry_count), DEPTH);
        check("R6 capacity pulse once", n_cap - c0, 1);
        check("R6 no overflow pulse", n_ovf - o0, 0);
        check("R9 done once at capacity", n_done - d0, 1);
        check("R6 finished", int'(finished), 1);
        check("R6 not running", int'(running), 0);
        check_entry("R6 last entry", DEPTH - 1, 1);
        for (int i = 0; i < 3; i++) toggle_hold(130);
        check("R6 edges after full ignored", int'(entry_count), DEPTH);
        check_entry("R6 last entry unchanged", DEPTH - 1, 1);
        check("R6 no second pulse", n_cap - c0, 1);
    endtask

    initial begin
        t_reset_state();
        t_idle_arm();
        t_intervals_and_wrap();
        t_capacity();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule